// File: doc/BRIEF.md
# Write-Miss-Policy Configurable Cache

This block is a small, fully associative, write-back data cache placed between a processor request port and a lower-level memory port. Each line holds one data word, a full-address tag, a valid bit and a dirty bit. Reads and writes that hit finish in one cycle. Misses stall the requester while the cache talks to memory over a request/acknowledge handshake whose latency may vary.

A static select input chooses how a write miss is handled. In allocate mode the cache fetches the line first and then merges the write into it. In write-around mode the write goes straight to memory and the cache is left untouched. A read miss always allocates. Two saturating counters, one for hits and one for misses, let the same access trace be run under both settings and compared. A clear input resets both counters.

Top module: `wma_cache`

## Requirements
- R1: A read that hits is answered with `rsp_valid` high and the cached word on `rsp_rdata` in the cycle after acceptance, and `req_ready` stays high.
- R2: A write that hits updates the cached word and marks the line dirty. It causes no memory transfer, and a later read of that address returns the new word.
- R3: With `alloc_on_wr`=1, a write miss reads the line from memory, installs it with the written word, and marks it dirty. The next access to that address hits.
- R4: With `alloc_on_wr`=0, a write miss performs exactly one memory write (`mem_we`=1) of the word to its address and leaves the cache contents unchanged. Repeated writes to an uncached address therefore each count as a miss.
- R5: A read miss installs the line fetched from memory and returns that word, under either setting of `alloc_on_wr`.
- R6: After reset the cache holds no valid line, both counters read 0, `req_ready` is 1, and `mem_req` and `rsp_valid` are 0.
- R7: On a miss, `req_ready` is low from the cycle after acceptance until the last memory acknowledge. `rsp_valid` is high in the cycle after that acknowledge, and `mem_req` is never high while `req_ready` is high.
- R8: Victim choice takes the lowest-index invalid line if one exists, and otherwise a round-robin pointer that starts at line 0 and advances on each replacement of a valid line. A dirty victim is written to memory before the fill.
- R9: Each accepted request adds one to exactly one of `hit_count` or `miss_count`. Both counters saturate at all-ones, and `cnt_clear` sets both to 0 in the next cycle.
- R10: In allocate mode, the trace write A, write A, write B, write B, write A on an empty cache gives 2 misses and 3 hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| alloc_on_wr | input | 1 | 1 = fetch-and-merge on write miss, 0 = write around to memory |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Cache can accept a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write word |
| rsp_valid | output | 1 | One-cycle response strobe for every accepted request |
| rsp_rdata | output | DW | Read word (valid with `rsp_valid` for reads) |
| mem_req | output | 1 | Memory transfer request, held until acknowledged |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Word to write to memory |
| mem_ack | input | 1 | One-cycle completion of the current memory transfer |
| mem_rdata | input | DW | Read word, valid with `mem_ack` |
| cnt_clear | input | 1 | Clears both counters |
| hit_count | output | CW | Saturating hit count |
| miss_count | output | CW | Saturating miss count |

## Verification
The properties assume that `mem_ack` is a single-cycle pulse given only while `mem_req` is high, and that `alloc_on_wr` changes only while the cache is idle. The memory model in the bench acknowledges after 0 to 2 idle cycles, drops the acknowledge in the following cycle, and never acknowledges without a request. The bench changes the policy select only across a reset. Requests are held until `req_ready` is seen and are sent one at a time, so every response can be matched to a single accepted request.

// File: rtl/wma_cache_pkg.sv
package wma_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WBACK    = 2'd1,
    ST_FILL     = 2'd2,
    ST_WRAROUND = 2'd3
  } cache_st_e;
endpackage

// File: rtl/cache_match.sv
module cache_match #(
  parameter int AW     = 16,
  parameter int NLINES = 4,
  parameter int IW     = 2
) (
  input  logic [NLINES-1:0]         valid,
  input  logic [NLINES-1:0][AW-1:0] tags,
  input  logic [AW-1:0]             addr,
  output logic                      hit,
  output logic [IW-1:0]             idx
);
  logic [NLINES-1:0] eq;

  for (genvar g = 0; g < NLINES; g++) begin : g_cmp
    assign eq[g] = valid[g] && (tags[g] == addr);
  end

  assign hit = |eq;

  always_comb begin
    idx = '0;
    for (int i = 0; i < NLINES; i++) begin
      if (eq[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/cache_victim.sv
module cache_victim #(
  parameter int NLINES = 4,
  parameter int IW     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] valid,
  input  logic              advance,
  output logic [IW-1:0]     victim,
  output logic              all_valid
);
  localparam logic [IW-1:0] LAST = IW'(NLINES - 1);

  logic [IW-1:0] rr_q, rr_d;

  assign all_valid = &valid;

  always_comb begin
    victim = rr_q;
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (!valid[i]) victim = IW'(i);
    end
  end

  always_comb begin
    rr_d = rr_q;
    if (advance) rr_d = (rr_q == LAST) ? '0 : rr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_d;
  end
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                    cnt_d = '0;
    else if (inc && ~&cnt_q)    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/wma_cache.sv
module wma_cache
  import wma_cache_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 32,
  parameter int NLINES = 4,
  parameter int CW     = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_on_wr,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  input  logic          cnt_clear,
  output logic [CW-1:0] hit_count,
  output logic [CW-1:0] miss_count
);
  localparam int IW = (NLINES > 1) ? $clog2(NLINES) : 1;

  // reset: asserted asynchronously, released after two clock edges
  logic rst_meta_q, rst_n_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_q    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_q    <= rst_meta_q;
    end
  end

  // line storage
  logic [NLINES-1:0]         valid_q, dirty_q;
  logic [NLINES-1:0][AW-1:0] tag_q;
  logic [NLINES-1:0][DW-1:0] data_q;

  cache_st_e      st_q, st_d;
  logic           pend_we_q;
  logic [AW-1:0]  pend_addr_q;
  logic [DW-1:0]  pend_wdata_q;
  logic [IW-1:0]  vict_q;

  logic           hit, all_valid, accept, alloc_adv;
  logic [IW-1:0]  hit_idx, vict_idx;
  logic           lw_en, lw_dirty;
  logic [IW-1:0]  lw_idx;
  logic [AW-1:0]  lw_tag;
  logic [DW-1:0]  lw_data;
  logic           rsp_d, rsp_valid_q;
  logic [DW-1:0]  rdata_d, rsp_data_q;

  cache_match #(.AW(AW), .NLINES(NLINES), .IW(IW)) u_match (
    .valid (valid_q),
    .tags  (tag_q),
    .addr  (req_addr),
    .hit   (hit),
    .idx   (hit_idx)
  );

  cache_victim #(.NLINES(NLINES), .IW(IW)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n_q),
    .valid     (valid_q),
    .advance   (alloc_adv),
    .victim    (vict_idx),
    .all_valid (all_valid)
  );

  assign req_ready = (st_q == ST_IDLE) && rst_n_q;
  assign accept    = req_valid && req_ready;

  // next state, line update and response
  always_comb begin
    st_d      = st_q;
    lw_en     = 1'b0;
    lw_idx    = hit_idx;
    lw_tag    = req_addr;
    lw_data   = req_wdata;
    lw_dirty  = 1'b1;
    alloc_adv = 1'b0;
    rsp_d     = 1'b0;
    rdata_d   = data_q[hit_idx];
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          if (hit) begin
            rsp_d = 1'b1;
            lw_en = req_we;
          end else if (req_we && !alloc_on_wr) begin
            st_d = ST_WRAROUND;
          end else begin
            alloc_adv = all_valid;
            st_d = (valid_q[vict_idx] && dirty_q[vict_idx]) ? ST_WBACK : ST_FILL;
          end
        end
      end
      ST_WBACK: begin
        if (mem_ack) st_d = ST_FILL;
      end
      ST_FILL: begin
        if (mem_ack) begin
          st_d     = ST_IDLE;
          rsp_d    = 1'b1;
          rdata_d  = mem_rdata;
          lw_en    = 1'b1;
          lw_idx   = vict_q;
          lw_tag   = pend_addr_q;
          lw_data  = pend_we_q ? pend_wdata_q : mem_rdata;
          lw_dirty = pend_we_q;
        end
      end
      ST_WRAROUND: begin
        if (mem_ack) begin
          st_d    = ST_IDLE;
          rsp_d   = 1'b1;
          rdata_d = pend_wdata_q;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) begin
      st_q        <= ST_IDLE;
      rsp_valid_q <= 1'b0;
      valid_q     <= '0;
      dirty_q     <= '0;
    end else begin
      st_q        <= st_d;
      rsp_valid_q <= rsp_d;
      if (lw_en) begin
        valid_q[lw_idx] <= 1'b1;
        dirty_q[lw_idx] <= lw_dirty;
      end
    end
  end

  // datapath registers with explicit enables, no reset
  always_ff @(posedge clk) begin
    if (accept) begin
      pend_we_q    <= req_we;
      pend_addr_q  <= req_addr;
      pend_wdata_q <= req_wdata;
      vict_q       <= vict_idx;
    end
    if (lw_en) begin
      tag_q[lw_idx]  <= lw_tag;
      data_q[lw_idx] <= lw_data;
    end
    if (rsp_d) rsp_data_q <= rdata_d;
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_data_q;

  assign mem_req   = (st_q != ST_IDLE);
  assign mem_we    = (st_q == ST_WBACK) || (st_q == ST_WRAROUND);
  assign mem_addr  = (st_q == ST_WBACK) ? tag_q[vict_q]  : pend_addr_q;
  assign mem_wdata = (st_q == ST_WBACK) ? data_q[vict_q] : pend_wdata_q;

  sat_counter #(.W(CW)) u_hits (
    .clk   (clk),
    .rst_n (rst_n_q),
    .clr   (cnt_clear),
    .inc   (accept && hit),
    .count (hit_count)
  );

  sat_counter #(.W(CW)) u_misses (
    .clk   (clk),
    .rst_n (rst_n_q),
    .clr   (cnt_clear),
    .inc   (accept && !hit),
    .count (miss_count)
  );
endmodule

// File: rtl/wma_cache_chk.sv
module wma_cache_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic          cnt_clear,
  input logic [CW-1:0] hit_count,
  input logic [CW-1:0] miss_count
);
  // R7: memory is quiet whenever new requests are taken
  p_mem_quiet_when_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req);

  // R7: a completed fill answers the requester in the next cycle
  p_rsp_after_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !mem_we) |=> rsp_valid);

  // R9: clear empties both counters
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> (hit_count == '0) && (miss_count == '0));

  // R9: a saturated hit counter stays put
  p_hit_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clear && (&hit_count)) |=> (&hit_count));

  // R9: a saturated miss counter stays put
  p_miss_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clear && (&miss_count)) |=> (&miss_count));

  // R9: at most one counter moves per cycle
  p_one_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clear |=> (hit_count == $past(hit_count)) || (miss_count == $past(miss_count)));

  // R7: no response while the requester may still be stalled on the same miss
  p_no_rsp_in_transfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |-> !rsp_valid);
endmodule

bind wma_cache wma_cache_chk #(.CW(CW)) u_wma_cache_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_ack    (mem_ack),
  .cnt_clear  (cnt_clear),
  .hit_count  (hit_count),
  .miss_count (miss_count)
);

// File: tb/test_wma_cache.sv
module test_wma_cache;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int CW = 32;

  logic          clk;
  logic          rst_n;
  logic          alloc_on_wr;
  logic          req_valid, req_ready, req_we;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          cnt_clear;
  logic [CW-1:0] hit_count, miss_count;

  wma_cache #(.AW(AW), .DW(DW), .NLINES(4), .CW(CW)) i_wma_cache (
    .clk(clk), .rst_n(rst_n), .alloc_on_wr(alloc_on_wr),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .cnt_clear(cnt_clear), .hit_count(hit_count), .miss_count(miss_count)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk;
  int n_fail;
  int mem_wr_cnt;

  typedef struct {
    logic          we;
    logic [DW-1:0] rdata;
    string         tag;
  } exp_t;
  exp_t exp_q[$];

  logic [DW-1:0] bmem [256];

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: variable latency, one-cycle acknowledge
  initial begin
    int dly;
    int seed;
    dly = 0;
    seed = 0;
    mem_ack = 1'b0;
    mem_rdata = '0;
    mem_wr_cnt = 0;
    for (int i = 0; i < 256; i++) bmem[i] = 32'hA000_0000 | i;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req) begin
        if (dly == 0) begin
          if (mem_we) begin
            bmem[mem_addr[7:0]] = mem_wdata;
            mem_wr_cnt++;
          end else begin
            mem_rdata = bmem[mem_addr[7:0]];
          end
          mem_ack = 1'b1;
          seed = (seed + 1) % 3;
          dly = seed;
        end else begin
          dly--;
        end
      end
    end
  end

  // monitor: pops the scoreboard on every response
  initial begin
    forever begin
      @(negedge clk);
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          chk(64'd1, 64'd0, "R7 unexpected response");
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (!e.we) chk(64'(rsp_rdata), 64'(e.rdata), e.tag);
        end
      end
    end
  end

  // driver: one request, expected outcome pushed to the scoreboard
  task automatic access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic exp_hit, input logic [DW-1:0] exp_rd, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1;
    req_we    = we;
    req_addr  = a;
    req_wdata = d;
    while (!req_ready) @(negedge clk);
    e.we = we;
    e.rdata = exp_rd;
    e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_hit) begin
      chk(64'(rsp_valid), 64'd1, {tag, " R1 hit response next cycle"});
      chk(64'(req_ready), 64'd1, {tag, " R1 ready kept on hit"});
    end else begin
      chk(64'(req_ready), 64'd0, {tag, " R7 stall on miss"});
    end
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic do_reset(input logic alloc);
    @(negedge clk);
    rst_n = 1'b0;
    alloc_on_wr = alloc;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_tests();
    int wr0;
    do_reset(1'b1);
    // R6: reset state
    chk(64'(req_ready), 64'd1, "R6 ready after reset");
    chk(64'(mem_req), 64'd0, "R6 no memory request");
    chk(64'(rsp_valid), 64'd0, "R6 no response");
    chk(64'(hit_count), 64'd0, "R6 hit count");
    chk(64'(miss_count), 64'd0, "R6 miss count");

    // R10 / R3: trace under write allocate
    access(1'b1, 16'd100, 32'h1111_0001, 1'b0, '0, "R3 write miss A");
    access(1'b1, 16'd100, 32'h1111_0002, 1'b1, '0, "R3 write A hits");
    access(1'b1, 16'd200, 32'h2222_0003, 1'b0, '0, "R3 write miss B");
    access(1'b1, 16'd200, 32'h2222_0004, 1'b1, '0, "R2 write B hits");
    access(1'b1, 16'd100, 32'h1111_0005, 1'b1, '0, "R2 write A hits");
    chk(64'(hit_count), 64'd3, "R10 hits");
    chk(64'(miss_count), 64'd2, "R10 misses");
    chk(64'(mem_wr_cnt), 64'd0, "R2 no memory writes on hits");
    chk(64'(bmem[100]), 64'hA000_0064, "R2 memory untouched by write-back line");
    access(1'b0, 16'd100, '0, 1'b1, 32'h1111_0005, "R1 R2 read back A");

    // R9: clear
    @(negedge clk);
    cnt_clear = 1'b1;
    @(negedge clk);
    cnt_clear = 1'b0;
    chk(64'(hit_count), 64'd0, "R9 hit cleared");
    chk(64'(miss_count), 64'd0, "R9 miss cleared");

    // R4 / R5: write around
    do_reset(1'b0);
    wr0 = mem_wr_cnt;
    access(1'b1, 16'd100, 32'h3333_0001, 1'b0, '0, "R4 write miss 1");
    chk(64'(bmem[100]), 64'h3333_0001, "R4 write reaches memory");
    access(1'b1, 16'd100, 32'h3333_0002, 1'b0, '0, "R4 write miss 2");
    chk(64'(miss_count), 64'd2, "R4 each write misses");
    chk(64'(hit_count), 64'd0, "R4 no hits");
    chk(64'(mem_wr_cnt - wr0), 64'd2, "R4 one memory write per miss");
    chk(64'(bmem[100]), 64'h3333_0002, "R4 memory holds last write");
    access(1'b0, 16'd100, '0, 1'b0, 32'h3333_0002, "R5 read miss allocates");
    access(1'b1, 16'd100, 32'h3333_0003, 1'b1, '0, "R5 write hits after read fill");
    access(1'b0, 16'd100, '0, 1'b1, 32'h3333_0003, "R2 read hit after write hit");
    chk(64'(hit_count), 64'd2, "R9 hit total");
    chk(64'(miss_count), 64'd3, "R9 miss total");

    // R8: eviction order and write-back
    do_reset(1'b1);
    for (int i = 1; i <= 4; i++)
      access(1'b1, AW'(i), 32'h4444_0000 | i, 1'b0, '0, "R8 fill line");
    access(1'b0, 16'd5, '0, 1'b0, 32'hA000_0005, "R8 read miss evicts");
    chk(64'(bmem[1]), 64'h4444_0001, "R8 dirty victim line0 written back");
    access(1'b0, 16'd5, '0, 1'b1, 32'hA000_0005, "R5 read after fill hits");
    access(1'b0, 16'd1, '0, 1'b0, 32'h4444_0001, "R8 refetch of evicted word");
    chk(64'(bmem[2]), 64'h4444_0002, "R8 round robin victim line1");
    access(1'b0, 16'd3, '0, 1'b1, 32'h4444_0003, "R8 untouched line still hits");
    chk(64'(hit_count), 64'd2, "R9 hits after eviction");
    chk(64'(miss_count), 64'd6, "R9 misses after eviction");
  endtask

  initial begin
    n_chk = 0;
    n_fail = 0;
    rst_n = 1'b0;
    alloc_on_wr = 1'b1;
    req_valid = 1'b0;
    req_we = 1'b0;
    req_addr = '0;
    req_wdata = '0;
    cnt_clear = 1'b0;
    fork
      run_tests();
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R7 watchdog actual=hung expected=complete");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule